// File: doc/BRIEF.md
# CPU Clock Control Unit

This unit sits between the oscillators of a small microcontroller and the CPU core. It accepts two clock-tick inputs: one from a fast main oscillator and one from a slow 32.768 kHz subsystem oscillator. Each input is an enable pulse in the system clock domain. From these it makes a CPU clock enable, a set of peripheral clock enables and a watch clock enable. It also makes the enable that keeps the main oscillator running.

Software sets two small registers. The rate register picks how many main ticks make one CPU cycle. The source register picks which oscillator drives the CPU, and it can request that the main oscillator be shut down. A new setting is held as pending and takes effect only when the current CPU cycle ends, so no CPU clock period is ever cut short.

Two standby modes exist. HALT stops the CPU clock enable while the peripherals keep running. STOP shuts down the main oscillator and every enable that depends on it. STOP is refused while the subsystem clock drives the CPU. A wake pulse leaves either mode and keeps the register settings.

Top module: `mcu_clkctl`

## Requirements
- R1: After reset, the main source is selected with rate code 0, main_osc_en_o is 1, and cpu_ce_o pulses once every 64 main ticks.
- R2: With the main source selected, rate code 0, 1, 2 and 3 gives one cpu_ce_o pulse per 64, 16, 8 and 4 main ticks respectively.
- R3: Writing 1 to source bit 0 selects the subsystem source, after which cpu_ce_o pulses once per 4 subsystem ticks.
- R4: A write to either register takes effect at the end of the CPU cycle in progress. That cycle keeps its old length.
- R5: A halt request puts the unit in HALT. There, cpu_ce_o stays 0 while per_ce_o keeps pulsing, and wake_i returns the unit to normal running.
- R6: A stop request while the main source is active sets main_osc_en_o to 0 and holds cpu_ce_o and per_ce_o at 0. After wake_i, operation resumes with the same rate setting.
- R7: A stop request while the subsystem source is active is ignored. main_osc_en_o stays 1 and cpu_ce_o keeps pulsing.
- R8: With the subsystem source active, source bit 1 set to 1 stops the main oscillator. main_osc_en_o goes to 0 and per_ce_o stays 0, while cpu_ce_o keeps running from the subsystem ticks.
- R9: A write that sets source bit 1 with bit 0 clear cannot stop the main oscillator, so main_osc_en_o stays 1.
- R10: per_ce_o bit k pulses once per 2^(k+1) main ticks while the main oscillator runs.
- R11: watch_ce_o repeats every subsystem tick one system clock later, in every mode and configuration.
- R12: cpu_ce_o is high for only one system clock cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| main_tick_i | input | 1 | One pulse per main oscillator cycle |
| sub_tick_i | input | 1 | One pulse per subsystem oscillator cycle |
| rate_we_i | input | 1 | Write strobe for the rate register |
| rate_i | input | 2 | New rate code |
| src_we_i | input | 1 | Write strobe for the source register |
| src_i | input | 2 | Bit 0: use subsystem source; bit 1: stop main oscillator |
| halt_req_i | input | 1 | Request to enter HALT |
| stop_req_i | input | 1 | Request to enter STOP |
| wake_i | input | 1 | Leave any standby mode |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | PER_N | Peripheral clock enables, bit k divides by 2^(k+1) |
| watch_ce_o | output | 1 | Watch clock enable from the subsystem ticks |
| main_osc_en_o | output | 1 | Main oscillator run enable |

## Verification
The bound checker tests these rules on every cycle: peripheral pulses stop whenever the main oscillator is off, the CPU enable is a single-cycle pulse and stays silent in HALT and STOP, a stop request under the subsystem source never enters STOP, and the active configuration changes only at a CPU-cycle boundary. Some behaviour can only be shown by the bench's scenarios. This covers the exact CPU periods for each rate code and for the subsystem source, the full length of the CPU cycle in which a write lands, and the peripheral and watch rates. It also covers keeping the settings across wake and refusing to shut down the main oscillator while it still drives the CPU.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'd0,
      MODE_HALT = 2'd1,
      MODE_STOP = 2'd2
   } sb_mode_e;

   typedef struct packed {
      logic       use_sub;
      logic       main_off;
      logic [1:0] rate;
   } clk_cfg_t;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkctl_cfg.sv
module clkctl_cfg
   import clkctl_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rate_we_i,
   input  logic [1:0] rate_i,
   input  logic       src_we_i,
   input  logic [1:0] src_i,
   input  logic       commit_i,
   output clk_cfg_t   act_o
);
   clk_cfg_t pend_q;
   clk_cfg_t act_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (rate_we_i) pend_q.rate <= rate_i;
         if (src_we_i) begin
            pend_q.use_sub  <= src_i[0];
            pend_q.main_off <= src_i[1];
         end
         if (commit_i) begin
            act_q.rate     <= pend_q.rate;
            act_q.use_sub  <= pend_q.use_sub;
            // the main oscillator may only be stopped while it is not the CPU source
            act_q.main_off <= pend_q.main_off & pend_q.use_sub;
         end
      end
   end

   assign act_o = act_q;

endmodule

// File: rtl/clkctl_standby.sv
module clkctl_standby
   import clkctl_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     halt_req_i,
   input  logic     stop_req_i,
   input  logic     stop_ok_i,
   input  logic     wake_i,
   output sb_mode_e mode_o
);
   sb_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (wake_i) begin
         mode_d = MODE_RUN;
      end else if (mode_q == MODE_RUN) begin
         if (stop_req_i && stop_ok_i) mode_d = MODE_STOP;
         else if (halt_req_i)         mode_d = MODE_HALT;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) mode_q <= MODE_RUN;
      else         mode_q <= mode_d;
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/clkctl_cpudiv.sv
module clkctl_cpudiv
   import clkctl_pkg::*;
#(
   parameter int unsigned DIV0    = 64,
   parameter int unsigned DIV1    = 16,
   parameter int unsigned DIV2    = 8,
   parameter int unsigned DIV3    = 4,
   parameter int unsigned SUB_DIV = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     main_tick_i,
   input  logic     sub_tick_i,
   input  clk_cfg_t cfg_i,
   input  logic     run_i,
   output logic     bnd_o,
   output logic     cpu_ce_o
);
   localparam int unsigned DMAX  = max_of(max_of(max_of(DIV0, DIV1), max_of(DIV2, DIV3)), SUB_DIV);
   localparam int unsigned CNT_W = $clog2(DMAX);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             tick;
   logic             ce_q;

   always_comb begin
      if (cfg_i.use_sub) begin
         term = CNT_W'(SUB_DIV - 1);
      end else begin
         case (cfg_i.rate)
            2'd0:    term = CNT_W'(DIV0 - 1);
            2'd1:    term = CNT_W'(DIV1 - 1);
            2'd2:    term = CNT_W'(DIV2 - 1);
            default: term = CNT_W'(DIV3 - 1);
         endcase
      end
   end

   assign tick  = cfg_i.use_sub ? sub_tick_i : main_tick_i;
   assign bnd_o = tick && (cnt_q == term);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ce_q  <= 1'b0;
      end else begin
         ce_q <= bnd_o && run_i;
         if (tick) cnt_q <= bnd_o ? '0 : cnt_q + 1'b1;
      end
   end

   assign cpu_ce_o = ce_q;

endmodule

// File: rtl/clkctl_perdiv.sv
module clkctl_perdiv #(
   parameter int unsigned PER_N = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             main_tick_i,
   output logic [PER_N-1:0] per_ce_o
);
   logic [PER_N-1:0] pcnt_q;
   logic [PER_N-1:0] tap;
   logic [PER_N-1:0] ce_q;

   for (genvar k = 0; k < PER_N; k++) begin : g_tap
      assign tap[k] = &pcnt_q[k:0];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pcnt_q <= '0;
         ce_q   <= '0;
      end else begin
         ce_q <= main_tick_i ? tap : '0;
         if (main_tick_i) pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assign per_ce_o = ce_q;

endmodule

// File: rtl/mcu_clkctl.sv
module mcu_clkctl
   import clkctl_pkg::*;
#(
   parameter int unsigned DIV0    = 64,
   parameter int unsigned DIV1    = 16,
   parameter int unsigned DIV2    = 8,
   parameter int unsigned DIV3    = 4,
   parameter int unsigned SUB_DIV = 4,
   parameter int unsigned PER_N   = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             main_tick_i,
   input  logic             sub_tick_i,
   input  logic             rate_we_i,
   input  logic [1:0]       rate_i,
   input  logic             src_we_i,
   input  logic [1:0]       src_i,
   input  logic             halt_req_i,
   input  logic             stop_req_i,
   input  logic             wake_i,
   output logic             cpu_ce_o,
   output logic [PER_N-1:0] per_ce_o,
   output logic             watch_ce_o,
   output logic             main_osc_en_o
);
   localparam int unsigned DMIN = (DIV0 < DIV1 ? DIV0 : DIV1) < (DIV2 < DIV3 ? DIV2 : DIV3)
                                ? (DIV0 < DIV1 ? DIV0 : DIV1) : (DIV2 < DIV3 ? DIV2 : DIV3);

   if (DMIN < 2) begin : g_bad_div
      $error("every main divide ratio must be at least 2");
   end
   if (SUB_DIV < 2) begin : g_bad_sub
      $error("subsystem divide ratio must be at least 2");
   end
   if (PER_N < 1 || PER_N > 16) begin : g_bad_per
      $error("PER_N must lie between 1 and 16");
   end

   clk_cfg_t act_cfg;
   sb_mode_e mode;
   logic     bnd;
   logic     main_run;
   logic     main_tick_g;
   logic     watch_q;

   assign main_run    = (mode != MODE_STOP) && !(act_cfg.use_sub && act_cfg.main_off);
   assign main_tick_g = main_tick_i && main_run;

   clkctl_cfg u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rate_we_i (rate_we_i),
      .rate_i    (rate_i),
      .src_we_i  (src_we_i),
      .src_i     (src_i),
      .commit_i  (bnd),
      .act_o     (act_cfg)
   );

   clkctl_standby u_sb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .halt_req_i (halt_req_i),
      .stop_req_i (stop_req_i),
      .stop_ok_i  (!act_cfg.use_sub),
      .wake_i     (wake_i),
      .mode_o     (mode)
   );

   clkctl_cpudiv #(
      .DIV0    (DIV0),
      .DIV1    (DIV1),
      .DIV2    (DIV2),
      .DIV3    (DIV3),
      .SUB_DIV (SUB_DIV)
   ) u_cpu (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .main_tick_i (main_tick_g),
      .sub_tick_i  (sub_tick_i),
      .cfg_i       (act_cfg),
      .run_i       (mode == MODE_RUN),
      .bnd_o       (bnd),
      .cpu_ce_o    (cpu_ce_o)
   );

   clkctl_perdiv #(
      .PER_N (PER_N)
   ) u_per (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .main_tick_i (main_tick_g),
      .per_ce_o    (per_ce_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) watch_q <= 1'b0;
      else         watch_q <= sub_tick_i;
   end

   assign watch_ce_o    = watch_q;
   assign main_osc_en_o = main_run;

endmodule

// File: rtl/mcu_clkctl_chk.sv
module mcu_clkctl_chk
   import clkctl_pkg::*;
#(
   parameter int unsigned PER_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_ce,
   input logic [PER_N-1:0] per_ce,
   input logic             main_en,
   input sb_mode_e         mode,
   input clk_cfg_t         act,
   input logic             bnd,
   input logic             stop_req,
   input logic             wake
);
   // R12: CPU enable never lasts two cycles
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ce |=> !cpu_ce);

   // R8: peripheral enables are silent after the main oscillator is off
   a_r8_per_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !main_en |=> (per_ce == '0));

   // R5: HALT suppresses the CPU enable
   a_r5_halt_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HALT) |=> !cpu_ce);

   // R6: STOP suppresses the CPU enable
   a_r6_stop_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STOP) |=> !cpu_ce);

   // R7: no STOP while the subsystem clock drives the CPU
   a_r7_stop_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && act.use_sub && !wake) |=> (mode != MODE_STOP));

   // R4: active configuration moves only at a CPU-cycle boundary
   a_r4_commit_at_bnd: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(act));

endmodule

bind mcu_clkctl mcu_clkctl_chk #(.PER_N(PER_N)) chk_i (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .cpu_ce   (cpu_ce_o),
   .per_ce   (per_ce_o),
   .main_en  (main_osc_en_o),
   .mode     (mode),
   .act      (act_cfg),
   .bnd      (bnd),
   .stop_req (stop_req_i),
   .wake     (wake_i)
);

// File: tb/mcu_clkctl_tb_top.sv
module mcu_clkctl_tb_top;
   localparam int PER_N = 4;
   localparam int SUBP  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             main_tick = 1'b1;
   logic             sub_tick = 1'b0;
   logic             rate_we = 1'b0;
   logic [1:0]       rate_d = '0;
   logic             src_we = 1'b0;
   logic [1:0]       src_d = '0;
   logic             halt_req = 1'b0;
   logic             stop_req = 1'b0;
   logic             wake = 1'b0;
   logic             cpu_ce;
   logic [PER_N-1:0] per_ce;
   logic             watch_ce;
   logic             main_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mcu_clkctl #(.PER_N(PER_N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .main_tick_i(main_tick), .sub_tick_i(sub_tick),
      .rate_we_i(rate_we), .rate_i(rate_d), .src_we_i(src_we), .src_i(src_d),
      .halt_req_i(halt_req), .stop_req_i(stop_req), .wake_i(wake),
      .cpu_ce_o(cpu_ce), .per_ce_o(per_ce), .watch_ce_o(watch_ce), .main_osc_en_o(main_en)
   );

   initial begin
      int sc = 0;
      forever begin
         @(negedge clk);
         sc = (sc + 1) % SUBP;
         sub_tick = (sc == 0);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      int n = 0;
      do begin @(negedge clk); n++; end while (!cpu_ce && n < 600);
   endtask

   task automatic interval(output int p);
      int n = 0;
      do begin @(negedge clk); n++; end while (!cpu_ce && n < 600);
      p = n;
   endtask

   task automatic period2(output int p);
      int d;
      wait_pulse();
      interval(d);
      interval(p);
   endtask

   task automatic count_win(input int cyc, output int c_cpu, output int c_w,
                            output int c_p0, output int c_pany, output int c_pk [PER_N]);
      c_cpu = 0; c_w = 0; c_p0 = 0; c_pany = 0;
      for (int k = 0; k < PER_N; k++) c_pk[k] = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         c_cpu += int'(cpu_ce);
         c_w   += int'(watch_ce);
         c_p0  += int'(per_ce[0]);
         c_pany += int'(per_ce != '0);
         for (int k = 0; k < PER_N; k++) c_pk[k] += int'(per_ce[k]);
      end
   endtask

   task automatic wr_rate(input logic [1:0] d);
      @(negedge clk); rate_we = 1'b1; rate_d = d;
      @(negedge clk); rate_we = 1'b0;
   endtask

   task automatic wr_src(input logic [1:0] d);
      @(negedge clk); src_we = 1'b1; src_d = d;
      @(negedge clk); src_we = 1'b0;
   endtask

   task automatic pulse_sig(input int which);
      @(negedge clk);
      if (which == 0) halt_req = 1'b1; else if (which == 1) stop_req = 1'b1; else wake = 1'b1;
      @(negedge clk);
      halt_req = 1'b0; stop_req = 1'b0; wake = 1'b0;
   endtask

   task automatic t_reset();
      int p, a, w, p0, pa;
      int pk [PER_N];
      @(negedge clk);
      chk("R1 main_osc_en after reset", int'(main_en), 1);
      chk("R1 cpu_ce idle after reset", int'(cpu_ce), 0);
      period2(p);
      chk("R1 default period", p, 64);
      count_win(64, a, w, p0, pa, pk);
      chk("R11 watch pulses per 64", w, 64 / SUBP);
   endtask

   task automatic t_boundary();
      int n = 0, p;
      wait_pulse();
      do begin
         @(negedge clk); n++;
         if (n == 10) begin rate_we = 1'b1; rate_d = 2'd3; end
         if (n == 11) rate_we = 1'b0;
      end while (!cpu_ce && n < 600);
      chk("R4 cycle in progress keeps length", n, 64);
      interval(p);
      chk("R4 next cycle uses new rate", p, 4);
      @(negedge clk);
      chk("R12 cpu_ce drops after one cycle", int'(cpu_ce), 0);
   endtask

   task automatic t_rates();
      int p;
      wr_rate(2'd2); period2(p); chk("R2 rate code 2", p, 8);
      wr_rate(2'd1); period2(p); chk("R2 rate code 1", p, 16);
      wr_rate(2'd0); period2(p); chk("R2 rate code 0", p, 64);
      wr_rate(2'd3); period2(p); chk("R2 rate code 3", p, 4);
   endtask

   task automatic t_per();
      int a, w, p0, pa;
      int pk [PER_N];
      count_win(64, a, w, p0, pa, pk);
      for (int k = 0; k < PER_N; k++)
         chk($sformatf("R10 per_ce[%0d] pulses per 64", k), pk[k], 64 >> (k + 1));
   endtask

   task automatic t_halt();
      int a, w, p0, pa, p;
      int pk [PER_N];
      pulse_sig(0);
      @(negedge clk);
      count_win(40, a, w, p0, pa, pk);
      chk("R5 cpu_ce silent in HALT", a, 0);
      chk("R5 per_ce[0] runs in HALT", p0, 20);
      pulse_sig(2);
      period2(p);
      chk("R5 cpu period after wake", p, 4);
   endtask

   task automatic t_stop();
      int a, w, p0, pa, p;
      int pk [PER_N];
      pulse_sig(1);
      @(negedge clk);
      chk("R6 main_osc_en off in STOP", int'(main_en), 0);
      count_win(40, a, w, p0, pa, pk);
      chk("R6 cpu_ce silent in STOP", a, 0);
      chk("R6 per_ce silent in STOP", pa, 0);
      chk("R11 watch runs in STOP", w, 40 / SUBP);
      pulse_sig(2);
      @(negedge clk);
      chk("R6 main_osc_en back after wake", int'(main_en), 1);
      period2(p);
      chk("R6 rate kept across STOP", p, 4);
   endtask

   task automatic t_sub();
      int p;
      wr_src(2'b01);
      period2(p);
      chk("R3 subsystem period", p, 4 * SUBP);
      pulse_sig(1);
      repeat (3) @(negedge clk);
      chk("R7 main_osc_en stays on", int'(main_en), 1);
      period2(p);
      chk("R7 cpu keeps running", p, 4 * SUBP);
   endtask

   task automatic t_main_off();
      int a, w, p0, pa, p;
      int pk [PER_N];
      wr_src(2'b11);
      wait_pulse();
      repeat (2) @(negedge clk);
      chk("R8 main_osc_en off", int'(main_en), 0);
      count_win(64, a, w, p0, pa, pk);
      chk("R8 per_ce silent with main off", pa, 0);
      chk("R11 watch runs with main off", w, 64 / SUBP);
      chk("R8 cpu pulses from subsystem", a, 2);
      period2(p);
      chk("R8 subsystem period", p, 4 * SUBP);
   endtask

   task automatic t_off_ignored();
      int a, w, p0, pa, p;
      int pk [PER_N];
      wr_src(2'b10);
      wait_pulse();
      repeat (2) @(negedge clk);
      chk("R9 main_osc_en stays on", int'(main_en), 1);
      count_win(64, a, w, p0, pa, pk);
      chk("R9 per_ce[0] running", p0, 32);
      period2(p);
      chk("R9 main period restored", p, 4);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_boundary();
      t_rates();
      t_per();
      t_halt();
      t_stop();
      t_sub();
      t_main_off();
      t_off_ignored();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule